// File: doc/BRIEF.md
# Row-Latch Read Energy Controller

This block controls the read path of a word-addressed memory whose physical rows are wider than one data word. Each row holds eight 16-bit words, and the default geometry is four banks of 64 rows, 4 KB in all. On a read that misses, the controller drives the bank and row select lines and pulses the decoder enable and read wordline for one cycle. It then captures the returned 128-bit row into a wide holding latch and delivers the addressed word through a registered 16-bit output.

A read to the row already held in the latch is a hit. It is answered from the latch through an eight-to-one word multiplexer one cycle after acceptance. On a hit the decoder enable and the wordline stay low and the select lines do not move, which saves the array activation energy. After one activation, the other seven words of the row, and any word read again, can be read this way. The controller also watches the array's write port: a write to the held row updates the matching latch word, including writes that land while that row is being fetched. A wordline activation counter and a hit flag on each result show whether suppression took place.

The controller has three states. IDLE accepts requests and answers hits. It moves to ACTIVATE on a miss (transition IDLE->ACTIVATE, "miss launch"); otherwise it stays in IDLE ("hit serve" or "idle wait"). ACTIVATE holds the decoder and wordline pulse and always moves to CAPTURE ("row fetch"). CAPTURE loads the latch and the output register and always returns to IDLE ("fill done").

Top module: `row_latch_reader`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, rd_valid, arr_rwl_en, arr_dec_en and wl_count are all zero, rd_ready is 1 and the latch holds no row.
- R2: A read accepted on edge E0 whose row is not latched raises arr_dec_en and arr_rwl_en together for exactly the cycle after E1. During that cycle {arr_bank, arr_row} equals rd_addr[10:3]. The result (rd_valid=1, rd_hit=0) appears after E3 for one cycle.
- R3: A read accepted on edge E0 whose bank and row match the latched row gives rd_valid=1 and rd_hit=1 after E1. No decoder or wordline pulse occurs and wl_count is unchanged.
- R4: arr_bank and arr_row change only on the edge that enters ACTIVATE. arr_dec_en and arr_rwl_en are high only in ACTIVATE.
- R5: The address splits as bank=rd_addr[10:9], row=rd_addr[8:3], word=rd_addr[2:0]. Word k is row bits [16k+15:16k], and rd_data returns that word.
- R6: After one miss on a row, reads of all eight words of that row cost one wordline activation in total.
- R7: A read with the same row index as the latched row but a different bank is a miss.
- R8: A write (wr_en=1) to a word of the latched row updates that latch word, so a later hit returns the new value. A write to any other row leaves the latched data unchanged.
- R9: Writes to the row being fetched that land on the edge ending ACTIVATE or on the edge ending CAPTURE are merged into the latch.
- R10: wl_count increments by one per ACTIVATE cycle and wraps modulo 2^CNT_W.
- R11: rd_ready is 0 from the cycle after a miss is accepted until the fill completes. Hits can be accepted on consecutive cycles.
- R12: A write that lands on the same edge that delivers a hit on that word does not affect that hit, which returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, taken on an edge where rd_ready is 1 |
| rd_addr | input | 11 | Word address {bank, row, word} |
| rd_ready | output | 1 | Controller can accept a request on the next edge |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_hit | output | 1 | Result was served from the latch |
| rd_data | output | 16 | Registered read word |
| wr_en | input | 1 | Array write taking place this cycle (snooped) |
| wr_addr | input | 11 | Word address of the array write |
| wr_data | input | 16 | Data of the array write |
| arr_bank | output | 2 | Bank select to the array decoders |
| arr_row | output | 6 | Row select to the array decoders |
| arr_dec_en | output | 1 | Row and bank decoder enable |
| arr_rwl_en | output | 1 | Read wordline pulse |
| arr_row_data | input | 128 | Row returned by the array one edge after the pulse |
| wl_count | output | CNT_W | Count of wordline activations |

## Verification
The bench builds the controller with CNT_W=4 and leaves word width, words per row, bank count and rows per bank at their defaults. A sixteen-miss sweep therefore wraps the activation counter, a case that would need 65536 fills at the default width. With the default geometry the bench reaches both ends of the bank and row ranges, including bank 3 row 63 and same-row accesses in different banks. It also covers writes that land in each cycle of a fill and on the edge that delivers a hit.

// File: rtl/rlr_pkg.sv
package rlr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACTIVATE = 2'd1,
        ST_CAPTURE  = 2'd2
    } rlr_state_e;
endpackage

// File: rtl/rlr_in_stage.sv
module rlr_in_stage #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              take,
    input  logic              drop,
    output logic              req_q,
    output logic [ADDR_W-1:0] addr_q
);
    // Host request flops: reload when the controller can take a request,
    // otherwise hold the pending miss until its fill completes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else if (take) begin
            req_q <= rd_req;
            if (rd_req) addr_q <= rd_addr;
        end else if (drop) begin
            req_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rlr_fsm.sv
module rlr_fsm
    import rlr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_q,
    input  logic             hit,
    output logic             start_fill,
    output logic             serve_hit,
    output logic             fetching,
    output logic             do_capture,
    output logic             ready,
    output logic [CNT_W-1:0] wl_count
);
    rlr_state_e state, state_nxt;

    // State register and activation counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wl_count <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_ACTIVATE) wl_count <= wl_count + CNT_W'(1);
        end
    end

    // Transitions.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (req_q && !hit) state_nxt = ST_ACTIVATE;
            ST_ACTIVATE: state_nxt = ST_CAPTURE;
            ST_CAPTURE:  state_nxt = ST_IDLE;
            default:     state_nxt = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        start_fill = 1'b0;
        serve_hit  = 1'b0;
        fetching   = 1'b0;
        do_capture = 1'b0;
        unique case (state)
            ST_IDLE: begin
                start_fill = req_q && !hit;
                serve_hit  = req_q && hit;
            end
            ST_ACTIVATE: fetching   = 1'b1;
            ST_CAPTURE:  do_capture = 1'b1;
            default: ;
        endcase
        ready = (state == ST_IDLE) && !start_fill;
    end
endmodule

// File: rtl/rlr_row_store.sv
module rlr_row_store #(
    parameter int WORD_W    = 16,
    parameter int ROW_WORDS = 8,
    parameter int TAG_W     = 8,
    localparam int OFS_W    = $clog2(ROW_WORDS),
    localparam int ROW_BITS = WORD_W * ROW_WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TAG_W-1:0]    rd_tag,
    input  logic [OFS_W-1:0]    rd_ofs,
    input  logic                start_fill,
    input  logic                fetching,
    input  logic                do_capture,
    input  logic [ROW_BITS-1:0] row_in,
    input  logic                wr_en,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [OFS_W-1:0]    wr_ofs,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                hit,
    output logic [TAG_W-1:0]    open_tag,
    output logic [WORD_W-1:0]   latch_word,
    output logic [WORD_W-1:0]   fill_word
);
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic              patch_v;
    logic [OFS_W-1:0]  patch_ofs;
    logic [WORD_W-1:0] patch_data;
    logic [WORD_W-1:0] lat    [ROW_WORDS];
    logic [WORD_W-1:0] merged [ROW_WORDS];
    logic              wr_match;

    assign wr_match = wr_en && (wr_tag == tag_q);
    assign hit      = valid_q && (tag_q == rd_tag);
    assign open_tag = tag_q;

    // Tag, valid flag and the one-word patch for a write seen in ACTIVATE
    // (the array read on that edge returns the row before the write).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            tag_q      <= '0;
            patch_v    <= 1'b0;
            patch_ofs  <= '0;
            patch_data <= '0;
        end else begin
            if (start_fill) begin
                tag_q   <= rd_tag;
                valid_q <= 1'b0;
                patch_v <= 1'b0;
            end
            if (fetching && wr_match) begin
                patch_v    <= 1'b1;
                patch_ofs  <= wr_ofs;
                patch_data <= wr_data;
            end
            if (do_capture) begin
                valid_q <= 1'b1;
                patch_v <= 1'b0;
            end
        end
    end

    // Row merge: array data, then the patch, then a write landing now.
    always_comb begin
        for (int w = 0; w < ROW_WORDS; w++) begin
            merged[w] = row_in[w*WORD_W +: WORD_W];
            if (patch_v && patch_ofs == OFS_W'(w)) merged[w] = patch_data;
            if (wr_match && wr_ofs == OFS_W'(w))   merged[w] = wr_data;
        end
    end

    // Wide holding latch.
    always_ff @(posedge clk) begin
        for (int w = 0; w < ROW_WORDS; w++) begin
            if (do_capture)
                lat[w] <= merged[w];
            else if (valid_q && wr_match && wr_ofs == OFS_W'(w))
                lat[w] <= wr_data;
        end
    end

    assign latch_word = lat[rd_ofs];
    assign fill_word  = merged[rd_ofs];
endmodule

// File: rtl/row_latch_reader.sv
module row_latch_reader #(
    parameter int WORD_W    = 16,
    parameter int ROW_WORDS = 8,
    parameter int BANKS     = 4,
    parameter int ROWS      = 64,
    parameter int CNT_W     = 16,
    localparam int OFS_W    = $clog2(ROW_WORDS),
    localparam int BANK_W   = $clog2(BANKS),
    localparam int ROWR_W   = $clog2(ROWS),
    localparam int TAG_W    = BANK_W + ROWR_W,
    localparam int ADDR_W   = TAG_W + OFS_W,
    localparam int ROW_BITS = WORD_W * ROW_WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic                rd_ready,
    output logic                rd_valid,
    output logic                rd_hit,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [BANK_W-1:0]   arr_bank,
    output logic [ROWR_W-1:0]   arr_row,
    output logic                arr_dec_en,
    output logic                arr_rwl_en,
    input  logic [ROW_BITS-1:0] arr_row_data,
    output logic [CNT_W-1:0]    wl_count
);
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;
    logic              hit, start_fill, serve_hit, fetching, do_capture;
    logic [TAG_W-1:0]  open_tag;
    logic [WORD_W-1:0] latch_word, fill_word;

    rlr_in_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .take(rd_ready), .drop(do_capture), .req_q(req_q), .addr_q(addr_q)
    );

    rlr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_q(req_q), .hit(hit),
        .start_fill(start_fill), .serve_hit(serve_hit), .fetching(fetching),
        .do_capture(do_capture), .ready(rd_ready), .wl_count(wl_count)
    );

    rlr_row_store #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_tag(addr_q[ADDR_W-1:OFS_W]), .rd_ofs(addr_q[OFS_W-1:0]),
        .start_fill(start_fill), .fetching(fetching), .do_capture(do_capture),
        .row_in(arr_row_data), .wr_en(wr_en),
        .wr_tag(wr_addr[ADDR_W-1:OFS_W]), .wr_ofs(wr_addr[OFS_W-1:0]),
        .wr_data(wr_data), .hit(hit), .open_tag(open_tag),
        .latch_word(latch_word), .fill_word(fill_word)
    );

    // Decoder selects come from the held tag, which moves only on a miss launch.
    assign arr_bank   = open_tag[TAG_W-1:ROWR_W];
    assign arr_row    = open_tag[ROWR_W-1:0];
    assign arr_dec_en = fetching;
    assign arr_rwl_en = fetching;

    // 16-bit output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_hit   <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= serve_hit || do_capture;
            rd_hit   <= serve_hit;
            if (serve_hit)       rd_data <= latch_word;
            else if (do_capture) rd_data <= fill_word;
        end
    end
endmodule

// File: rtl/rlr_checker.sv
module rlr_checker #(
    parameter int BANK_W = 2,
    parameter int ROWR_W = 6,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic              rd_hit,
    input logic [BANK_W-1:0] arr_bank,
    input logic [ROWR_W-1:0] arr_row,
    input logic              arr_dec_en,
    input logic              arr_rwl_en,
    input logic [CNT_W-1:0]  wl_count
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (wl_count == '0 && !rd_valid && !arr_rwl_en && !arr_dec_en));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rwl_en |=> !arr_rwl_en);

    assert_miss_follows_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_hit) |-> $past(arr_rwl_en, 2));

    assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_hit) |-> ($past(!arr_dec_en) && $stable(wl_count)));

    assert_select_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_dec_en |-> $stable({arr_bank, arr_row}));

    assert_count_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wl_count) |-> $past(arr_rwl_en));

    assert_busy_in_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        arr_dec_en |-> !rd_ready);
endmodule

bind row_latch_reader rlr_checker #(
    .BANK_W(BANK_W), .ROWR_W(ROWR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_hit(rd_hit), .arr_bank(arr_bank), .arr_row(arr_row),
    .arr_dec_en(arr_dec_en), .arr_rwl_en(arr_rwl_en), .wl_count(wl_count)
);

// File: tb/sim_row_latch_reader.sv
module sim_row_latch_reader;
    localparam int CNT_W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req = 1'b0;
    logic [10:0]  rd_addr = '0;
    logic         rd_ready, rd_valid, rd_hit;
    logic [15:0]  rd_data;
    logic         wr_en = 1'b0;
    logic [10:0]  wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic [1:0]   arr_bank;
    logic [5:0]   arr_row;
    logic         arr_dec_en, arr_rwl_en;
    logic [127:0] arr_row_data;
    logic [CNT_W-1:0] wl_count;

    always #2 clk = ~clk;

    row_latch_reader #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_hit(rd_hit),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .arr_bank(arr_bank), .arr_row(arr_row), .arr_dec_en(arr_dec_en),
        .arr_rwl_en(arr_rwl_en), .arr_row_data(arr_row_data), .wl_count(wl_count)
    );

    // Behavioural array: read-first, row returned one edge after the pulse.
    logic [127:0] mem [256];
    logic [127:0] arr_q = '0;
    always @(posedge clk) begin
        if (wr_en) mem[wr_addr[10:3]][wr_addr[2:0]*16 +: 16] <= wr_data;
        if (arr_rwl_en) arr_q <= mem[{arr_bank, arr_row}];
    end
    assign arr_row_data = arr_q;

    function automatic logic [15:0] pat(int r, int k);
        return {r[7:0], 4'hC, 1'b0, k[2:0]};
    endfunction

    function automatic logic [15:0] exp_word(logic [10:0] a);
        return mem[a[10:3]][a[2:0]*16 +: 16];
    endfunction

    function automatic logic [10:0] mk(int b, int r, int o);
        return {b[1:0], r[5:0], o[2:0]};
    endfunction

    int checks = 0;
    int fails  = 0;
    int dec_cycles = 0;
    logic [7:0] last_sel = '0;
    logic [CNT_W-1:0] exp_wl = '0;
    bit done = 1'b0;

    always @(negedge clk) if (arr_dec_en) begin
        dec_cycles++;
        last_sel = {arr_bank, arr_row};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic do_read(input logic [10:0] a, input bit exp_hit, input string req);
        int lat;
        int d0;
        logic [CNT_W-1:0] w0;
        logic [7:0] sel0;
        while (!rd_ready) @(negedge clk);
        w0 = wl_count; d0 = dec_cycles; sel0 = {arr_bank, arr_row};
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        lat = 1;
        if (!exp_hit) begin
            chk(rd_ready == 1'b0, "R11", "ready during miss", 32'(rd_ready), 0);
            exp_wl = exp_wl + CNT_W'(1);
        end
        while (!rd_valid && lat < 12) begin @(negedge clk); lat++; end
        chk(rd_valid == 1'b1, req, "rd_valid", 32'(rd_valid), 1);
        chk(rd_hit == exp_hit, req, "rd_hit", 32'(rd_hit), 32'(exp_hit));
        chk(rd_data == exp_word(a), "R5", "rd_data", 32'(rd_data), 32'(exp_word(a)));
        chk(lat == (exp_hit ? 2 : 4), req, "latency", 32'(lat), exp_hit ? 2 : 4);
        chk(CNT_W'(wl_count - w0) == (exp_hit ? 0 : 1), "R10", "wl_count step",
            32'(CNT_W'(wl_count - w0)), exp_hit ? 0 : 1);
        if (exp_hit)
            chk(dec_cycles == d0 && {arr_bank, arr_row} == sel0, "R3",
                "decoder activity on hit", 32'(dec_cycles - d0), 0);
        else
            chk(last_sel == a[10:3], "R2", "row select", 32'(last_sel), 32'(a[10:3]));
    endtask

    task automatic do_write(input logic [10:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // {expected hit, bank, row, word}
    localparam logic [11:0] VEC [11] = '{
        {1'b0, 2'd0, 6'd5,  3'd3},
        {1'b1, 2'd0, 6'd5,  3'd0},
        {1'b1, 2'd0, 6'd5,  3'd7},
        {1'b0, 2'd1, 6'd5,  3'd3},   // R7: same row index, other bank
        {1'b1, 2'd1, 6'd5,  3'd1},
        {1'b0, 2'd0, 6'd5,  3'd1},
        {1'b0, 2'd3, 6'd63, 3'd7},
        {1'b1, 2'd3, 6'd63, 3'd0},
        {1'b0, 2'd3, 6'd62, 3'd0},
        {1'b0, 2'd0, 6'd0,  3'd0},
        {1'b1, 2'd0, 6'd0,  3'd0}
    };

    initial begin
        logic [15:0] orig;
        logic [CNT_W-1:0] w0;
        for (int r = 0; r < 256; r++)
            for (int k = 0; k < 8; k++)
                mem[r][k*16 +: 16] = pat(r, k);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(rd_valid == 0 && arr_rwl_en == 0 && arr_dec_en == 0, "R1",
            "outputs in reset", {29'd0, rd_valid, arr_rwl_en, arr_dec_en}, 0);
        chk(wl_count == 0, "R1", "wl_count in reset", 32'(wl_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_ready == 1'b1 && rd_valid == 1'b0, "R1", "ready after reset",
            {30'd0, rd_ready, rd_valid}, 32'h2);

        // Vector table: R2, R3, R5, R7
        for (int i = 0; i < 11; i++)
            do_read(VEC[i][10:0], VEC[i][11], VEC[i][11] ? "R3" : "R2");

        // R6: one activation for a whole row
        w0 = wl_count;
        do_read(mk(2, 10, 0), 1'b0, "R6");
        for (int k = 1; k < 8; k++) do_read(mk(2, 10, k), 1'b1, "R6");
        chk(CNT_W'(wl_count - w0) == 1, "R6", "activations for row",
            32'(CNT_W'(wl_count - w0)), 1);

        // R8: snooped writes on and off the latched row
        do_write(mk(2, 10, 4), 16'hBEEF);
        do_read(mk(2, 10, 4), 1'b1, "R8");
        chk(rd_data == 16'hBEEF, "R8", "updated latch word", 32'(rd_data), 32'hBEEF);
        do_write(mk(2, 11, 4), 16'h0F0F);
        do_read(mk(2, 10, 4), 1'b1, "R8");
        chk(rd_data == 16'hBEEF, "R8", "other-row write ignored", 32'(rd_data), 32'hBEEF);

        // R9: writes landing during the fill
        while (!rd_ready) @(negedge clk);
        orig = exp_word(mk(1, 20, 2));
        rd_req = 1'b1; rd_addr = mk(1, 20, 2);
        exp_wl = exp_wl + CNT_W'(1);
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        chk(arr_rwl_en == 1'b1, "R2", "pulse in ACTIVATE", 32'(arr_rwl_en), 1);
        wr_en = 1'b1; wr_addr = mk(1, 20, 5); wr_data = 16'h1234;
        @(negedge clk);
        wr_addr = mk(1, 20, 6); wr_data = 16'h5678;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_valid && !rd_hit && rd_data == orig, "R9", "fill result",
            32'(rd_data), 32'(orig));
        do_read(mk(1, 20, 5), 1'b1, "R9");
        chk(rd_data == 16'h1234, "R9", "write in ACTIVATE merged", 32'(rd_data), 32'h1234);
        do_read(mk(1, 20, 6), 1'b1, "R9");
        chk(rd_data == 16'h5678, "R9", "write in CAPTURE merged", 32'(rd_data), 32'h5678);

        // R12: write on the delivering edge does not affect that hit
        orig = exp_word(mk(1, 20, 7));
        rd_req = 1'b1; rd_addr = mk(1, 20, 7);
        @(negedge clk);
        rd_req = 1'b0;
        wr_en = 1'b1; wr_addr = mk(1, 20, 7); wr_data = 16'h9ABC;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_valid && rd_hit && rd_data == orig, "R12", "old value on write edge",
            32'(rd_data), 32'(orig));
        do_read(mk(1, 20, 7), 1'b1, "R12");
        chk(rd_data == 16'h9ABC, "R12", "new value afterwards", 32'(rd_data), 32'h9ABC);

        // R11: back-to-back hits
        rd_req = 1'b1; rd_addr = mk(1, 20, 0);
        @(negedge clk);
        chk(rd_ready == 1'b1, "R11", "ready after hit accept", 32'(rd_ready), 1);
        rd_addr = mk(1, 20, 1);
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_valid && rd_hit && rd_data == exp_word(mk(1, 20, 0)), "R11",
            "first pipelined hit", 32'(rd_data), 32'(exp_word(mk(1, 20, 0))));
        @(negedge clk);
        chk(rd_valid && rd_hit && rd_data == exp_word(mk(1, 20, 1)), "R11",
            "second pipelined hit", 32'(rd_data), 32'(exp_word(mk(1, 20, 1))));

        // R10: counter wrap over sixteen misses
        for (int i = 0; i < 16; i++) do_read(mk(2, 30 + (i % 2), i % 8), 1'b0, "R10");
        chk(wl_count == exp_wl, "R10", "wl_count total mod 2^CNT_W",
            32'(wl_count), 32'(exp_wl));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule